// File: doc/BRIEF.md
# Register-Access I2C Target

This block is a 7-bit-addressed I2C target that gives a bus master read and write access to a bank of eleven 8-bit registers. SCL and SDA are first oversampled by a system clock that runs at least eight times faster than SCL. The block detects START, repeated START and STOP, and acknowledges a control byte only when that byte carries its own address. It holds a register pointer and drives SDA only as an open-drain pull-down enable.

The register file sits outside the block and connects through a plain internal bus. The bus has a pointer output, write data, a one-cycle write strobe, a one-cycle read strobe and a read-data input, and that input must reflect the addressed register combinationally. A master writes by sending the control byte, one pointer byte and then data bytes. To read, the master sets the pointer the same way, issues a repeated START and sends a control byte with the read bit set. A mode input selects how the pointer behaves. In sequential mode it advances after every data byte and wraps from the last register to the first. In byte mode it stays put, so the master can poll one register by clocking further bytes.

Top module: `i2c_reg_slave`

## Requirements
- R1: The control byte is matched MSB first as 0,1,0,0, then strapAddr[2], strapAddr[1], strapAddr[0], then the direction bit (0 = write, 1 = read). On a match, the target pulls SDA low during the ninth clock.
- R2: In a write transfer the target acknowledges the pointer byte and every data byte that follows.
- R3: A data byte is committed only after its ACK clock ends. This appears as a single-cycle regWe with regAddr equal to the current pointer and regWdata equal to the byte as received.
- R4: A STOP or a repeated START that arrives before the eighth bit of a data byte has been clocked in discards that byte. No regWe is issued and the register keeps its value.
- R5: After a repeated START and a read control byte, the target returns the pointed register MSB first. regRe pulses for one cycle when the byte is fetched, and regWe and regRe are never active together.
- R6: With byteMode = 0, the pointer advances after every data byte, written or read, and goes from 0x0A to 0x00.
- R7: With byteMode = 1, the pointer does not advance. Repeated data bytes all write to, or read from, the same register.
- R8: A pointer byte above 0x0A sets the pointer to 0x00, so regAddr never exceeds 0x0A.
- R9: A control byte that does not match gets no ACK. Later bytes are ignored, with no ACK and no strobe, until the next START.
- R10: If the master sends NACK after a read byte, the target releases SDA and leaves it released until the next START.
- R11: sdaOe changes only while SCL is low. The block works with SCL quarter-periods of 20 and 80 system clocks.
- R12: During and right after reset, sdaOe, regWe and regRe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL as seen on the bus |
| sdaIn | input | 1 | SDA as seen on the bus |
| strapAddr | input | 3 | Low three bits of the target address |
| byteMode | input | 1 | 1 = freeze pointer, 0 = sequential |
| sdaOe | output | 1 | 1 = pull SDA low |
| regAddr | output | 4 | Register pointer |
| regWdata | output | 8 | Data byte to write |
| regWe | output | 1 | Write strobe, one cycle |
| regRe | output | 1 | Read strobe, one cycle |
| regRdata | input | 8 | Data of the addressed register |

## Verification
The write commit and the pointer advance happen on the same clock edge, the one that ends a data byte's ACK. The strobe must therefore carry the old pointer while the register moves to the next address, or stays put in byte mode. The bench provokes this with sequential writes that cross 0x0A and with repeated writes in byte mode. A scoreboard checks the address and data of every strobe against a queue of expected pairs, which the driver fills from its own pointer model. Read-back of those registers then confirms the wrap and the freeze through the bus.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RX_CTRL, ST_RX_ADDR, ST_RX_DATA,
    ST_ACK_CTRL, ST_ACK_ADDR, ST_ACK_DATA, ST_TX_DATA, ST_TX_ACK
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rxShift;
    logic ptrLoad;
    logic ptrStep;
    logic txLoad;
    logic txShift;
    logic wrCommit;
  } dpCtl_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [1:0] sclMeta, sdaMeta;
  logic sclS, sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclMeta <= 2'b11;
      sdaMeta <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclMeta <= {sclMeta[0], sclIn};
      sdaMeta <= {sdaMeta[0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclMeta[1];
  assign sdaS     = sdaMeta[1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_reg_pkg::*;
#(
  parameter logic [3:0] DEV_PREFIX = 4'b0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaS,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [2:0]        strapAddr,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  output dpCtl_t            ctl,
  output logic              sdaOe
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  busState_t state, nxtState;
  logic [3:0] bitCnt, nxtCnt;
  logic       mAck, nxtAck;
  logic       ctrlHit;

  assign ctrlHit = (rxByte[7:1] == {DEV_PREFIX, strapAddr});

  always_comb begin
    nxtState = state;
    nxtCnt   = bitCnt;
    nxtAck   = mAck;
    ctl      = '0;
    if (stopDet) begin
      nxtState = ST_IDLE;
    end else if (startDet) begin
      nxtState = ST_RX_CTRL;
      nxtCnt   = '0;
    end else begin
      unique case (state)
        ST_RX_CTRL, ST_RX_ADDR, ST_RX_DATA: begin
          if (sclRise && bitCnt < LAST_BIT) begin
            ctl.rxShift = 1'b1;
            nxtCnt      = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == LAST_BIT) begin
            nxtCnt = '0;
            if (state == ST_RX_CTRL) begin
              nxtState = ctrlHit ? ST_ACK_CTRL : ST_IDLE;
            end else if (state == ST_RX_ADDR) begin
              nxtState    = ST_ACK_ADDR;
              ctl.ptrLoad = 1'b1;
            end else begin
              nxtState = ST_ACK_DATA;
            end
          end
        end
        ST_ACK_CTRL: if (sclFall) begin
          if (rxByte[0]) begin
            nxtState   = ST_TX_DATA;
            ctl.txLoad = 1'b1;
          end else begin
            nxtState = ST_RX_ADDR;
          end
        end
        ST_ACK_ADDR: if (sclFall) nxtState = ST_RX_DATA;
        ST_ACK_DATA: if (sclFall) begin
          ctl.wrCommit = 1'b1;
          ctl.ptrStep  = 1'b1;
          nxtState     = ST_RX_DATA;
        end
        ST_TX_DATA: if (sclFall) begin
          if (bitCnt == LAST_BIT - 4'd1) begin
            nxtState = ST_TX_ACK;
            nxtCnt   = '0;
          end else begin
            ctl.txShift = 1'b1;
            nxtCnt      = bitCnt + 4'd1;
          end
        end
        ST_TX_ACK: begin
          if (sclRise) begin
            nxtAck      = ~sdaS;
            ctl.ptrStep = 1'b1;
          end else if (sclFall) begin
            if (mAck) begin
              nxtState   = ST_TX_DATA;
              ctl.txLoad = 1'b1;
            end else begin
              nxtState = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      mAck   <= 1'b0;
    end else begin
      state  <= nxtState;
      bitCnt <= nxtCnt;
      mAck   <= nxtAck;
    end
  end

  assign sdaOe = (state == ST_ACK_CTRL) || (state == ST_ACK_ADDR) ||
                 (state == ST_ACK_DATA) || ((state == ST_TX_DATA) && !txMsb);
endmodule

// File: rtl/i2c_slave_dp.sv
module i2c_slave_dp
  import i2c_reg_pkg::*;
#(
  parameter int REG_COUNT = 11,
  localparam int AW = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              sdaS,
  input  logic              byteMode,
  input  logic [BYTE_W-1:0] regRdata,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic [AW-1:0]     ptr
);
  localparam logic [AW-1:0] LAST_A = AW'(REG_COUNT - 1);

  logic [BYTE_W-1:0] txByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      txByte <= '1;
      ptr    <= '0;
    end else begin
      if (ctl.rxShift) rxByte <= {rxByte[BYTE_W-2:0], sdaS};
      if (ctl.txLoad)       txByte <= regRdata;
      else if (ctl.txShift) txByte <= {txByte[BYTE_W-2:0], 1'b1};
      if (ctl.ptrLoad)
        ptr <= (rxByte > BYTE_W'(REG_COUNT - 1)) ? '0 : rxByte[AW-1:0];
      else if (ctl.ptrStep && !byteMode)
        ptr <= (ptr == LAST_A) ? '0 : ptr + AW'(1);
    end
  end

  assign txMsb = txByte[BYTE_W-1];
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter int         REG_COUNT  = 11,
  parameter logic [3:0] DEV_PREFIX = 4'b0100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [2:0]  strapAddr,
  input  logic        byteMode,
  output logic        sdaOe,
  output logic [3:0]  regAddr,
  output logic [7:0]  regWdata,
  output logic        regWe,
  output logic        regRe,
  input  logic [7:0]  regRdata
);
  localparam int AW = $clog2(REG_COUNT);

  logic sdaS, sclRise, sclFall, startDet, stopDet, txMsb;
  logic [BYTE_W-1:0] rxByte;
  logic [AW-1:0] ptr;
  dpCtl_t ctl;

  i2c_line_sync u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaS(sdaS),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet)
  );

  i2c_slave_ctrl #(.DEV_PREFIX(DEV_PREFIX)) u_ctrl (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .strapAddr(strapAddr),
    .rxByte(rxByte), .txMsb(txMsb), .ctl(ctl), .sdaOe(sdaOe)
  );

  i2c_slave_dp #(.REG_COUNT(REG_COUNT)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaS(sdaS), .byteMode(byteMode),
    .regRdata(regRdata), .rxByte(rxByte), .txMsb(txMsb), .ptr(ptr)
  );

  assign regAddr  = 4'(ptr);
  assign regWdata = rxByte;
  assign regWe    = ctl.wrCommit;
  assign regRe    = ctl.txLoad;
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int REG_COUNT = 11
) (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       byteMode,
  input logic       sdaOe,
  input logic [3:0] regAddr,
  input logic       regWe,
  input logic       regRe
);
  localparam logic [3:0] LAST_A = 4'(REG_COUNT - 1);

  // R5: strobes are mutually exclusive
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWe, regRe}));

  // R6: sequential wrap after the last register
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !byteMode && regAddr == LAST_A) |=> (regAddr == 4'd0));

  // R7: frozen pointer in byte mode
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && byteMode) |=> $stable(regAddr));

  // R8: pointer stays inside the map
  a_r8_range: assert property (@(posedge clk) disable iff (!rstN)
    regAddr <= LAST_A);

  // R11: SDA enable moves only while SCL is low
  a_r11_sda_low_scl: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.REG_COUNT(REG_COUNT)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .byteMode(byteMode), .sdaOe(sdaOe),
  .regAddr(regAddr), .regWe(regWe), .regRe(regRe)
);

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic byteMode = 1'b0;
  logic sdaOe, regWe, regRe;
  logic [3:0] regAddr;
  logic [7:0] regWdata, regRdata;
  logic sdaBus;
  logic [7:0] mem [11];
  logic [7:0] expMem [11];
  logic [11:0] sbQ [$];
  int nChecks = 0, nErr = 0, qtr = 20;

  always #4 clk = ~clk;
  assign sdaBus = sdaM & ~sdaOe;

  i2c_reg_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .strapAddr(STRAP),
    .byteMode(byteMode), .sdaOe(sdaOe), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRe(regRe), .regRdata(regRdata)
  );

  // register file model outside the block
  always @(posedge clk) if (regWe) mem[regAddr] <= regWdata;
  assign regRdata = (regAddr <= 4'd10) ? mem[regAddr] : 8'h00;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every write strobe must match the queue head
  always @(negedge clk) begin
    if (rstN && regWe) begin
      if (sbQ.size() == 0) check(1'b0, "R9", "unexpected write", {regAddr, regWdata}, 0);
      else begin
        automatic logic [11:0] e = sbQ.pop_front();
        check({regAddr, regWdata} == e, "R3", "write strobe addr/data", {regAddr, regWdata}, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; tick(qtr); sclM = 1'b1; tick(qtr);
    sdaM = 1'b0; tick(qtr); sclM = 1'b0; tick(qtr);
  endtask

  task automatic stopC();
    sdaM = 1'b0; tick(qtr); sclM = 1'b1; tick(qtr); sdaM = 1'b1; tick(qtr);
  endtask

  task automatic sendByte(input logic [7:0] b, input int nb, output bit ack);
    ack = 1'b0;
    for (int i = 7; i > 7 - nb; i--) begin
      sdaM = b[i]; tick(qtr); sclM = 1'b1; tick(2 * qtr); sclM = 1'b0; tick(qtr);
    end
    if (nb == 8) begin
      sdaM = 1'b1; tick(qtr); sclM = 1'b1; tick(qtr);
      ack = !sdaBus; tick(qtr); sclM = 1'b0; tick(qtr);
    end
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sdaM = 1'b1; tick(qtr); sclM = 1'b1; tick(qtr);
      b = {b[6:0], sdaBus}; tick(qtr); sclM = 1'b0; tick(qtr);
    end
    sdaM = giveAck ? 1'b0 : 1'b1; tick(qtr); sclM = 1'b1; tick(2 * qtr);
    sclM = 1'b0; tick(qtr); sdaM = 1'b1;
  endtask

  function automatic int stepPtr(input int p);
    return byteMode ? p : ((p == 10) ? 0 : p + 1);
  endfunction

  task automatic wrSeq(input logic [7:0] a, input int n, input logic [7:0] seed,
                       input string req);
    bit ack;
    int p;
    startC();
    sendByte({4'b0100, STRAP, 1'b0}, 8, ack);
    check(ack, "R1", "control byte ACK", ack, 1);
    sendByte(a, 8, ack);
    check(ack, "R2", "pointer byte ACK", ack, 1);
    p = (a > 8'd10) ? 0 : int'(a);
    for (int i = 0; i < n; i++) begin
      automatic logic [7:0] d = seed + 8'(i * 37);
      sbQ.push_back({4'(p), d});
      expMem[p] = d;
      sendByte(d, 8, ack);
      check(ack, req, "data byte ACK", ack, 1);
      p = stepPtr(p);
    end
    stopC();
  endtask

  task automatic setPtrRestart(input logic [7:0] a);
    bit ack;
    startC();
    sendByte({4'b0100, STRAP, 1'b0}, 8, ack);
    sendByte(a, 8, ack);
    startC();
    sendByte({4'b0100, STRAP, 1'b1}, 8, ack);
    check(ack, "R5", "read control ACK", ack, 1);
  endtask

  task automatic rdSeq(input logic [7:0] a, input int n, input string req);
    logic [7:0] b;
    int p;
    setPtrRestart(a);
    p = (a > 8'd10) ? 0 : int'(a);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b);
      check(b == expMem[p], req, "read data", b, expMem[p]);
      p = stepPtr(p);
    end
    stopC();
  endtask

  initial begin
    int wd = 0;
    while (wd < 190000) begin @(negedge clk); wd++; end
    check(1'b0, "WD", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    for (int i = 0; i < 11; i++) begin mem[i] = 8'h00; expMem[i] = 8'h00; end
    tick(5);
    check(!sdaOe && !regWe && !regRe, "R12", "outputs in reset", {sdaOe, regWe, regRe}, 0);
    rstN = 1'b1;
    tick(5);
    check(!sdaOe && !regWe && !regRe, "R12", "outputs after reset", {sdaOe, regWe, regRe}, 0);

    // R3 R2: fill all registers, then write across the wrap (R6)
    wrSeq(8'h00, 11, 8'h10, "R2");
    wrSeq(8'h09, 4, 8'h51, "R6");
    rdSeq(8'h00, 11, "R5");
    rdSeq(8'h09, 4, "R6");

    // R7: byte mode writes and reads stay on one register
    byteMode = 1'b1;
    wrSeq(8'h03, 3, 8'hA2, "R7");
    rdSeq(8'h03, 3, "R7");
    byteMode = 1'b0;

    // R8: out-of-range pointer byte lands on register 0
    wrSeq(8'h3C, 2, 8'hC4, "R8");
    rdSeq(8'h00, 2, "R8");

    // R9: wrong strap bits, then wrong fixed prefix
    startC();
    sendByte({4'b0100, STRAP ^ 3'b011, 1'b0}, 8, ack);
    check(!ack, "R9", "no ACK on strap mismatch", ack, 0);
    sendByte(8'h02, 8, ack);
    check(!ack, "R9", "pointer byte ignored", ack, 0);
    sendByte(8'hEE, 8, ack);
    check(!ack, "R9", "data byte ignored", ack, 0);
    stopC();
    startC();
    sendByte({4'b1100, STRAP, 1'b0}, 8, ack);
    check(!ack, "R9", "no ACK on prefix mismatch", ack, 0);
    stopC();
    rdSeq(8'h02, 1, "R9");

    // R4: STOP in the middle of a data byte
    startC();
    sendByte({4'b0100, STRAP, 1'b0}, 8, ack);
    sendByte(8'h05, 8, ack);
    sendByte(8'h99, 4, ack);
    stopC();
    rdSeq(8'h05, 1, "R4");

    // R4: repeated START in the middle of a data byte, then read pointer 6
    startC();
    sendByte({4'b0100, STRAP, 1'b0}, 8, ack);
    sendByte(8'h06, 8, ack);
    sendByte(8'h77, 5, ack);
    startC();
    sendByte({4'b0100, STRAP, 1'b1}, 8, ack);
    check(ack, "R4", "read after aborted byte ACK", ack, 1);
    recvByte(1'b0, b);
    check(b == expMem[6], "R4", "register 6 untouched", b, expMem[6]);
    stopC();

    // R10: after NACK the bus stays released
    setPtrRestart(8'h04);
    recvByte(1'b0, b);
    check(b == expMem[4], "R10", "byte before NACK", b, expMem[4]);
    recvByte(1'b0, b);
    check(b == 8'hFF, "R10", "SDA released after NACK", b, 8'hFF);
    stopC();

    // R11: slower SCL
    qtr = 80;
    wrSeq(8'h02, 2, 8'h33, "R11");
    rdSeq(8'h02, 2, "R11");
    qtr = 20;

    tick(10);
    check(sbQ.size() == 0, "R3", "all expected writes seen", sbQ.size(), 0);
    check(!sdaOe, "R10", "SDA released at end", sdaOe, 0);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule